// File: doc/BRIEF.md
# Bridge-Drive PWM Output Steering

This block sits behind an existing duty-cycle generator and takes its single PWM stream onto four switch-drive outputs, named A to D, for a motor power stage. The stream itself is never regenerated: the block delays it, complements it and routes it according to a drive mode. The modes are single-output, half-bridge with complementary outputs and a programmable dead band, full-bridge forward and full-bridge reverse.

When the direction of a full-bridge drive is reversed, every switch is held off for one whole PWM period. The new diagonal is only enabled after that. A trip input overrides everything and drives the four pins to a programmable idle pattern. The trip is latched. It is released only at the start of a PWM period, when re-arming is enabled and the trip input is low.

The output pattern is registered. Outputs are active high, so a 1 turns the corresponding switch on. A PWM period starts on a rising edge of the input stream, that is, on a clock where the stream is sampled high after having been sampled low.

Top module: `pwm_bridge_steer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four outputs are 0.
- R2: With mode 2'b00 (single), output A equals the PWM input sampled one clock earlier, and outputs B, C and D are 0.
- R3: With mode 2'b01 (half bridge), A is 1 only when the last dead+1 input samples (through the previous clock) were all 1. B is 1 only when the last dead+1 samples were all 0. C and D are 0, and A and B are never 1 together.
- R4: In half-bridge mode with a dead count of 0, A is the delayed PWM and B is its exact complement.
- R5: With mode 2'b10 and direction 0 applied (forward), A is 1, D equals the previous-clock PWM sample, and B and C are 0.
- R6: With mode 2'b10 and direction 1 applied (reverse), C is 1, B equals the previous-clock PWM sample, and A and D are 0.
- R7: In full-bridge mode, a change of the direction input makes all outputs 0 from the next clock. They stay 0 until the second period start after the change. The new pattern appears from the first sample of that period.
- R8: The trip input sampled high makes the outputs equal the idle pattern on the next clock. The trip stays latched after the input falls.
- R9: A latched trip clears only at a period start where the re-arm input is 1 and the trip input is 0. It never clears while the re-arm input is 0.
- R10: With mode 2'b11 all outputs are 0.
- R11: In single and half-bridge modes the direction input has no effect on the outputs, and no blanking occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM stream from the duty-cycle generator |
| mode | input | 2 | Drive mode: 00 single, 01 half, 10 full, 11 off |
| dir | input | 1 | Full-bridge direction: 0 forward, 1 reverse |
| dead_cnt | input | DT_W | Dead band in clock cycles (half-bridge) |
| trip_in | input | 1 | Auto-shutdown request, active high |
| rearm | input | 1 | Permits the latched trip to clear at a period start |
| idle_lvl | input | 4 | Pin levels while tripped, bit 0 = A ... bit 3 = D |
| drv_out | output | 4 | Switch drives, bit 0 = A, 1 = B, 2 = C, 3 = D |

## Verification
The assertions take for granted that the mode, direction and idle pattern are sampled on the same clock edge as the outputs they produce. Each property therefore relates the outputs to the previous cycle's controls and state. They also assume that the dead count never exceeds the saturation value of the stable-time counter. The stimulus changes inputs only between clock edges and keeps the dead count between 0 and 5, well below that limit. Direction reversals, trips and re-arms are applied at arbitrary points of the PWM period, including during blanking.

// File: rtl/pbs_pkg.sv
// Shared types for the bridge-drive PWM steering block.
// Assumes: outputs are indexed A=0, B=1, C=2, D=3.
package pbs_pkg;
    localparam int NUM_OUT = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_HALF   = 2'b01,
        MODE_FULL   = 2'b10,
        MODE_OFF    = 2'b11
    } drive_mode_e;

    typedef enum logic [1:0] {
        BLK_RUN        = 2'b00,
        BLK_WAIT_START = 2'b01,
        BLK_WAIT_END   = 2'b10
    } blank_state_e;
endpackage

// File: rtl/pbs_edge_track.sv
// Registers the PWM stream, detects period starts and measures how long the
// stream has been stable, giving dead-band-delayed high and low enables.
// Assumes: dead_cnt never exceeds 2**DT_W-1 (counter saturates there).
module pbs_edge_track #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            pwm_q,
    output logic            period_start,
    output logic            on_hi,
    output logic            on_lo
);
    localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

    logic [DT_W-1:0] stable_cnt;

    // Sample the stream and count cycles since its last change (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q      <= 1'b0;
            stable_cnt <= CNT_MAX;
        end else begin
            pwm_q <= pwm_in;
            if (pwm_in != pwm_q)
                stable_cnt <= '0;
            else if (stable_cnt != CNT_MAX)
                stable_cnt <= stable_cnt + 1'b1;
        end
    end

    // Period start and dead-band-qualified levels.
    always_comb begin
        period_start = pwm_in & ~pwm_q;
        on_hi        = pwm_q  && (stable_cnt >= dead_cnt);
        on_lo        = !pwm_q && (stable_cnt >= dead_cnt);
    end
endmodule

// File: rtl/pbs_dir_blank.sv
// Tracks the applied full-bridge direction. On a direction change it blanks
// the bridge until one complete PWM period has elapsed, then applies it.
// Assumes: period_start pulses for one cycle at each PWM rising edge.
module pbs_dir_blank (
    input  logic clk,
    input  logic rst_n,
    input  logic full_sel,
    input  logic dir,
    input  logic period_start,
    output logic dir_q,
    output logic blank
);
    import pbs_pkg::*;

    blank_state_e state;

    // Direction sequencing: wait for a period start, then a full period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BLK_RUN;
            dir_q <= 1'b0;
        end else if (!full_sel) begin
            state <= BLK_RUN;
            dir_q <= dir;
        end else begin
            case (state)
                BLK_RUN:
                    if (dir != dir_q) state <= BLK_WAIT_START;
                BLK_WAIT_START:
                    if (period_start) state <= BLK_WAIT_END;
                BLK_WAIT_END:
                    if (period_start) begin
                        state <= BLK_RUN;
                        dir_q <= dir;
                    end
                default:
                    state <= BLK_RUN;
            endcase
        end
    end

    // Bridge is dark whenever a reversal is in progress.
    always_comb blank = (state != BLK_RUN);
endmodule

// File: rtl/pbs_trip_latch.sv
// Latches the auto-shutdown request and releases it only at a period start
// with re-arm enabled and the request input low.
// Assumes: trip_in is already synchronous to clk.
module pbs_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_in,
    input  logic rearm,
    input  logic period_start,
    output logic tripped
);
    // Set has priority over release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tripped <= 1'b0;
        else if (trip_in)
            tripped <= 1'b1;
        else if (tripped && period_start && rearm)
            tripped <= 1'b0;
    end
endmodule

// File: rtl/pwm_bridge_steer.sv
// Top level: steers one PWM stream onto four bridge drives according to the
// mode and direction, with dead band, reversal blanking and latched trip.
// Assumes: all inputs synchronous to clk; outputs active high.
module pwm_bridge_steer #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic [1:0]      mode,
    input  logic            dir,
    input  logic [DT_W-1:0] dead_cnt,
    input  logic            trip_in,
    input  logic            rearm,
    input  logic [3:0]      idle_lvl,
    output logic [3:0]      drv_out
);
    import pbs_pkg::*;

    drive_mode_e        mode_e;
    logic               pwm_q_w, start_w, on_hi_w, on_lo_w;
    logic               dir_q_w, blank_w, trip_q_w;
    logic [NUM_OUT-1:0] pattern, next_out;

    assign mode_e = drive_mode_e'(mode);

    pbs_edge_track #(.DT_W(DT_W)) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_in       (pwm_in),
        .dead_cnt     (dead_cnt),
        .pwm_q        (pwm_q_w),
        .period_start (start_w),
        .on_hi        (on_hi_w),
        .on_lo        (on_lo_w)
    );

    pbs_dir_blank u_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_sel     (mode_e == MODE_FULL),
        .dir          (dir),
        .period_start (start_w),
        .dir_q        (dir_q_w),
        .blank        (blank_w)
    );

    pbs_trip_latch u_trip (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_in      (trip_in),
        .rearm        (rearm),
        .period_start (start_w),
        .tripped      (trip_q_w)
    );

    // Mode-dependent routing of the stream onto {D,C,B,A}.
    always_comb begin
        case (mode_e)
            MODE_SINGLE: pattern = {3'b000, pwm_q_w};
            MODE_HALF:   pattern = {2'b00, on_lo_w, on_hi_w};
            MODE_FULL: begin
                if (blank_w)
                    pattern = 4'b0000;
                else if (dir_q_w)
                    pattern = {1'b0, 1'b1, pwm_q_w, 1'b0};
                else
                    pattern = {pwm_q_w, 1'b0, 1'b0, 1'b1};
            end
            default:     pattern = 4'b0000;
        endcase
        next_out = (trip_in || trip_q_w) ? idle_lvl : pattern;
    end

    // One output flop per drive pin.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) drv_out[i] <= 1'b0;
            else        drv_out[i] <= next_out[i];
        end
    end
endmodule

// File: rtl/pbs_checker.sv
// Property checker for pwm_bridge_steer, attached by bind below.
// Assumes: controls sampled on edge k determine the outputs seen on edge k+1.
module pbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       trip_in,
    input logic [3:0] idle_lvl,
    input logic [3:0] drv_out,
    input logic       blank,
    input logic       dir_q,
    input logic       tripped
);
    a_r8_trip_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        trip_in |=> (drv_out == $past(idle_lvl)));

    a_r2_single_only_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00 && !$past(trip_in) && !$past(tripped))
        |-> (drv_out[3:1] == 3'b000));

    a_r3_half_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01 && !$past(trip_in) && !$past(tripped))
        |-> (!(drv_out[0] && drv_out[1]) && drv_out[3:2] == 2'b00));

    a_r5_full_forward: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && !$past(blank) && !$past(dir_q)
         && !$past(trip_in) && !$past(tripped))
        |-> (drv_out[0] && !drv_out[1] && !drv_out[2]));

    a_r7_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && $past(blank)
         && !$past(trip_in) && !$past(tripped))
        |-> (drv_out == 4'b0000));

    a_r10_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11 && !$past(trip_in) && !$past(tripped))
        |-> (drv_out == 4'b0000));
endmodule

bind pwm_bridge_steer pbs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .trip_in  (trip_in),
    .idle_lvl (idle_lvl),
    .drv_out  (drv_out),
    .blank    (blank_w),
    .dir_q    (dir_q_w),
    .tripped  (trip_q_w)
);

// File: tb/tb_pwm_bridge_steer.sv
module tb_pwm_bridge_steer;
    localparam int DT_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic            dir = 1'b0;
    logic [DT_W-1:0] dead_cnt = '0;
    logic            trip_in = 1'b0;
    logic            rearm = 1'b0;
    logic [3:0]      idle_lvl = 4'b0000;
    logic [3:0]      drv_out;

    int tests = 0;
    int fails = 0;

    // Behavioural expectation state
    logic m_last = 1'b0;
    int   m_run  = 1000;
    int   m_bst  = 0;
    logic m_adir = 1'b0;
    logic m_sdl  = 1'b0;

    always #2 clk = ~clk;

    pwm_bridge_steer #(.DT_W(DT_W)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode(mode), .dir(dir),
        .dead_cnt(dead_cnt), .trip_in(trip_in), .rearm(rearm),
        .idle_lvl(idle_lvl), .drv_out(drv_out)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: drv_out=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] expect_out();
        logic hi, lo;
        int   need;
        need = int'(dead_cnt) + 1;
        hi = m_last && (m_run >= need);
        lo = !m_last && (m_run >= need);
        if (trip_in || m_sdl) return idle_lvl;
        case (mode)
            2'b00: return {3'b000, m_last};
            2'b01: return {2'b00, lo, hi};
            2'b10: begin
                if (m_bst != 0) return 4'b0000;
                if (m_adir)     return {1'b0, 1'b1, m_last, 1'b0};
                return {m_last, 2'b00, 1'b1};
            end
            default: return 4'b0000;
        endcase
    endfunction

    // One clock: predict, advance the model, then compare away from the edge.
    task automatic step(input string tag);
        logic [3:0] exp;
        logic       rise;
        string      t;
        @(posedge clk);
        exp  = expect_out();
        t    = tag;
        if (t == "") begin
            if (trip_in || m_sdl)      t = "R8";
            else if (mode == 2'b00)    t = "R2";
            else if (mode == 2'b01)    t = (dead_cnt == 0) ? "R4" : "R3";
            else if (mode == 2'b11)    t = "R10";
            else if (m_bst != 0)       t = "R7";
            else                       t = m_adir ? "R6" : "R5";
        end
        rise = pwm_in && !m_last;
        if (mode != 2'b10) begin
            m_adir = dir; m_bst = 0;
        end else begin
            case (m_bst)
                0: if (dir != m_adir) m_bst = 1;
                1: if (rise) m_bst = 2;
                default: if (rise) begin m_bst = 0; m_adir = dir; end
            endcase
        end
        if (trip_in) m_sdl = 1'b1;
        else if (m_sdl && rise && rearm) m_sdl = 1'b0;
        if (pwm_in == m_last) begin
            if (m_run < 1000) m_run++;
        end else m_run = 1;
        m_last = pwm_in;
        #1;
        check(t, drv_out, exp);
    endtask

    // Drive a PWM of period p and high time h for n cycles.
    task automatic run_pwm(input int p, input int h, input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            pwm_in = ((c % p) < h);
            step(tag);
        end
    endtask

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog: drv_out=%b expected completion", drv_out);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset and on the first cycle out of it
        repeat (3) @(posedge clk);
        #1;
        check("R1", drv_out, 4'b0000);
        rst_n = 1'b1;
        step("R1");

        // Sweep of modes, dead bands and waveforms (R2 R3 R4 R5 R10)
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 6; d++)
                for (int w = 0; w < 3; w++) begin
                    mode = 2'(m);
                    dead_cnt = DT_W'(d);
                    case (w)
                        0: run_pwm(8, 3, 24, "");
                        1: run_pwm(10, 7, 30, "");
                        default: run_pwm(6, 1, 18, "");
                    endcase
                end

        // R6 and R7: reverse and back, changes landing mid-period
        mode = 2'b10; dead_cnt = '0;
        run_pwm(8, 4, 5, "");
        dir = 1'b1;
        run_pwm(8, 4, 43, "");
        dir = 1'b0;
        run_pwm(9, 2, 40, "");
        dir = 1'b1;
        run_pwm(7, 5, 40, "");

        // R11: direction toggles ignored in single and half modes
        for (int m = 0; m < 2; m++) begin
            mode = 2'(m); dead_cnt = 4'd2;
            for (int k = 0; k < 8; k++) begin
                dir = ~dir;
                run_pwm(8, 3, 5, "R11");
            end
        end

        // R8: trip pulse latches, no re-arm so it holds
        mode = 2'b10; dir = 1'b0; idle_lvl = 4'b1010; rearm = 1'b0;
        run_pwm(8, 4, 40, "");
        trip_in = 1'b1;
        run_pwm(8, 4, 2, "R8");
        trip_in = 1'b0;
        run_pwm(8, 4, 30, "R8");

        // R9: trip held high keeps it latched even with re-arm
        rearm = 1'b1; trip_in = 1'b1;
        run_pwm(8, 4, 16, "R9");
        trip_in = 1'b0;
        run_pwm(8, 4, 30, "R9");

        // R8/R9 in half mode with another idle pattern
        mode = 2'b01; dead_cnt = 4'd1; idle_lvl = 4'b0101; rearm = 1'b0;
        run_pwm(10, 6, 20, "");
        trip_in = 1'b1;
        run_pwm(10, 6, 1, "R8");
        trip_in = 1'b0;
        run_pwm(10, 6, 25, "R9");
        rearm = 1'b1;
        run_pwm(10, 6, 30, "R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule